// File: doc/BRIEF.md
# Programmable Event Counter Bank with Sampling Trigger

This block holds a small set of programmable event counters for performance monitoring. Each counter picks one line from a vector of single-cycle event pulses and counts it only when the current privilege level and the mark bit of the running context pass that counter's filters. Each counter runs in one of three modes. In the off mode it neither counts nor is captured. In the count mode it counts and is copied into a shadow register whenever the snapshot strobe fires. In the trigger mode it raises a sample request each time it has seen a programmed number of events, and then starts a new interval from zero.

Only one counter may act as the trigger at a time. A control write that would make a second counter a trigger is dropped in full. While no counter is a trigger, the sampling source is taken to be an external timer, and the mark filters then have no effect. Software programs the bank through a single write port and reads captured values through a snapshot read port. Each counter has a sticky overflow flag that records a wrap.

Top module: `evctr_bank`

## Requirements
- R1: The mode field of a control word is bits [1:0]: 0 = off, 1 = count, 2 = trigger, 3 = off. An off counter holds its value, ignores events, and is not captured by a snapshot.
- R2: The event-select field is bits [8 +: log2(NUM_EVT)] (bits [10:8] for 8 events). A counting counter adds one on each clock edge at which the selected event bit is high and all filters pass. Other event bits have no effect.
- R3: The privilege filter is bits [17:16]. Value 1 counts only while `priv_sup_i` is 0 (user). Value 2 counts only while `priv_sup_i` is 1 (supervisor). Values 0 and 3 count at either level.
- R4: The mark filter is bits [19:18]. Value 1 counts only while `ctx_mark_i` is 1. Value 2 counts only while it is 0. Values 0 and 3 count always. The mark filter applies only while some counter is in trigger mode; otherwise it is ignored.
- R5: A trigger counter that counts an event which brings its count to the programmed interval clears to zero at that edge. `sample_req_o` is then high for the following cycle, so intervals run back to back with no lost events. An interval of 0 behaves as 1.
- R6: A control write selecting trigger mode for a counter is dropped entirely, with no change and no clear, while a different counter is in trigger mode.
- R7: The interval register (register 1) has no effect on a counter outside trigger mode, and writing it does not clear the counter.
- R8: An accepted control write (register 0) clears that counter's count to zero.
- R9: A high `snap_i` copies, at one edge, the pre-edge value of every count-mode counter into its shadow. Shadows of off and trigger counters keep their old values. `rd_data_o` shows the shadow selected by `rd_idx_i`.
- R10: A count-mode counter wraps from all ones to zero and sets its bit of `ovf_o`. The bit stays set until a write to register 2 of that counter with data bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set, and a set in the same cycle as a clear wins.
- R11: After reset every counter is off, every count, shadow and overflow bit is zero, and `sample_req_o` is low.
- R12: The write address is {counter index, register[1:0]}. Register 0 is control, register 1 is interval, register 2 is overflow clear, and register 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT | Event pulses, one bit per source |
| priv_sup_i | input | 1 | 1 while the running code is supervisor level |
| ctx_mark_i | input | 1 | Mark bit of the running context |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | log2(NUM_CTR)+2 | Counter index and register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| snap_i | input | 1 | Snapshot strobe |
| rd_idx_i | input | log2(NUM_CTR) | Shadow register to read |
| rd_data_o | output | CTR_W | Selected shadow value |
| sample_req_o | output | 1 | One-cycle sample request from the trigger counter |
| ovf_o | output | NUM_CTR | Sticky overflow flags |

## Verification
The bench builds the bank with four counters, eight event lines and 8-bit counters. The narrow width puts a counter wrap within 256 events, so the wrap, the sticky flag and its clear are all checked directly. Four counters are enough to hold a trigger while other counters try to claim trigger mode, run under opposite privilege filters, or sit idle in the off mode. Snapshot values flow through a scoreboard queue, and sample requests are counted against the number of completed intervals.

// File: rtl/evctr_pkg.sv
// Shared types and field positions for the event counter bank.
// Assumes a 32-bit configuration word.
package evctr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_TRIG  = 2'd2
    } ctr_mode_e;

    typedef enum logic [1:0] {
        PRIV_ANY  = 2'd0,
        PRIV_USER = 2'd1,
        PRIV_SUP  = 2'd2
    } priv_flt_e;

    typedef enum logic [1:0] {
        MARK_ANY = 2'd0,
        MARK_SET = 2'd1,
        MARK_CLR = 2'd2
    } mark_flt_e;

    localparam int CFG_DW   = 32;
    localparam int SEL_LSB  = 8;
    localparam int PRIV_LSB = 16;
    localparam int MARK_LSB = 18;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_IVL  = 2'd1;
    localparam logic [1:0] REG_OVF  = 2'd2;

    typedef struct packed {
        ctr_mode_e  mode;
        priv_flt_e  priv;
        mark_flt_e  mark;
        logic [7:0] sel;
    } ctr_cfg_t;

    // Decode a control word; the reserved code 3 of each field maps to its default.
    function automatic ctr_cfg_t decode_ctrl(input logic [CFG_DW-1:0] d);
        ctr_cfg_t c;
        case (d[1:0])
            2'd1:    c.mode = MODE_COUNT;
            2'd2:    c.mode = MODE_TRIG;
            default: c.mode = MODE_OFF;
        endcase
        case (d[PRIV_LSB +: 2])
            2'd1:    c.priv = PRIV_USER;
            2'd2:    c.priv = PRIV_SUP;
            default: c.priv = PRIV_ANY;
        endcase
        case (d[MARK_LSB +: 2])
            2'd1:    c.mark = MARK_SET;
            2'd2:    c.mark = MARK_CLR;
            default: c.mark = MARK_ANY;
        endcase
        c.sel = d[SEL_LSB +: 8];
        return c;
    endfunction

endpackage

// File: rtl/evctr_qual.sv
// Event qualifier: picks one event line and applies the privilege and
// mark filters. Purely combinational. Assumes NUM_EVT <= 256.
module evctr_qual
    import evctr_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [7:0]         sel_i,
    input  priv_flt_e          priv_i,
    input  mark_flt_e          mark_flt_i,
    input  logic               sup_i,
    input  logic               mark_i,
    input  logic               mark_en_i,
    output logic               qual_o
);
    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [8:0] EVT_LIM = 9'(NUM_EVT);

    logic evt_hit;
    logic priv_ok;
    logic mark_ok;

    // Select the event line; out-of-range selects never fire.
    always_comb begin
        if ({1'b0, sel_i} < EVT_LIM) evt_hit = evt_i[sel_i[SEL_W-1:0]];
        else                         evt_hit = 1'b0;
    end

    // Privilege level filter.
    always_comb begin
        case (priv_i)
            PRIV_USER: priv_ok = !sup_i;
            PRIV_SUP:  priv_ok = sup_i;
            default:   priv_ok = 1'b1;
        endcase
    end

    // Context mark filter, bypassed while the timer is the sample source.
    always_comb begin
        if (!mark_en_i) mark_ok = 1'b1;
        else begin
            case (mark_flt_i)
                MARK_SET: mark_ok = mark_i;
                MARK_CLR: mark_ok = !mark_i;
                default:  mark_ok = 1'b1;
            endcase
        end
    end

    assign qual_o = evt_hit && priv_ok && mark_ok;

endmodule

// File: rtl/evctr_cell.sv
// One counter: counts qualified events, reloads at the interval in
// trigger mode, wraps with a sticky overflow flag in count mode, and
// holds a shadow copy loaded by the snapshot strobe.
module evctr_cell
    import evctr_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctr_mode_e        mode_i,
    input  logic             qual_i,
    input  logic [CTR_W-1:0] interval_i,
    input  logic             ctrl_wr_i,
    input  logic             ovf_clr_i,
    input  logic             snap_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic [CTR_W-1:0] shadow_o,
    output logic             ovf_o,
    output logic             fire_o
);
    logic [CTR_W-1:0] cnt_q;
    logic [CTR_W:0]   next_ext;
    logic             hit;
    logic             wrap;
    logic             counting;

    assign next_ext = {1'b0, cnt_q} + (CTR_W+1)'(1);
    assign counting = (mode_i != MODE_OFF) && qual_i;
    assign hit      = (mode_i == MODE_TRIG) && qual_i && (next_ext >= {1'b0, interval_i});
    assign wrap     = (mode_i == MODE_COUNT) && qual_i && (&cnt_q);

    // Count register: clear on reconfiguration, reload on interval hit.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (ctrl_wr_i) cnt_q <= '0;
        else if (hit)       cnt_q <= '0;
        else if (counting)  cnt_q <= next_ext[CTR_W-1:0];
    end

    // Sample request pulse, one cycle after the interval-completing event.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_o <= 1'b0;
        else        fire_o <= hit && !ctrl_wr_i;
    end

    // Sticky overflow flag; a new wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_o <= 1'b0;
        else if (wrap)      ovf_o <= 1'b1;
        else if (ovf_clr_i) ovf_o <= 1'b0;
    end

    // Shadow capture of count-mode counters on the snapshot strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                             shadow_o <= '0;
        else if (snap_i && mode_i == MODE_COUNT) shadow_o <= cnt_q;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/evctr_bank.sv
// Event counter bank top: configuration registers, the single-trigger
// interlock, per-counter qualifier and counter cells, and the shadow
// read port. Assumes CTR_W <= 32 and NUM_EVT <= 256.
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_EVT-1:0]                           evt_i,
    input  logic                                         priv_sup_i,
    input  logic                                         ctx_mark_i,
    input  logic                                         cfg_we_i,
    input  logic [((NUM_CTR > 1) ? $clog2(NUM_CTR) : 1)+1:0] cfg_addr_i,
    input  logic [31:0]                                  cfg_wdata_i,
    input  logic                                         snap_i,
    input  logic [((NUM_CTR > 1) ? $clog2(NUM_CTR) : 1)-1:0] rd_idx_i,
    output logic [CTR_W-1:0]                             rd_data_o,
    output logic                                         sample_req_o,
    output logic [NUM_CTR-1:0]                           ovf_o
);
    localparam int CIDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int ADDR_W = CIDX_W + 2;
    localparam logic [CIDX_W:0] CTR_LIM = (CIDX_W+1)'(NUM_CTR);

    logic [CIDX_W-1:0]        wr_ctr;
    logic [1:0]               wr_reg;
    ctr_cfg_t                 new_cfg;
    logic                     trig_active;

    logic [NUM_CTR-1:0]       trig_vec;
    logic [NUM_CTR-1:0]       off_vec;
    logic [NUM_CTR-1:0]       cnt_vec;
    logic [NUM_CTR-1:0]       ctrl_wr_vec;
    logic [NUM_CTR-1:0]       ovf_clr_vec;
    logic [NUM_CTR-1:0]       fire_vec;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR*CTR_W-1:0] shd_flat;
    logic [CTR_W-1:0]         shd_arr [NUM_CTR];

    assign wr_ctr      = cfg_addr_i[ADDR_W-1:2];
    assign wr_reg      = cfg_addr_i[1:0];
    assign new_cfg     = decode_ctrl(cfg_wdata_i);
    assign trig_active = |trig_vec;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        ctr_cfg_t         cfg_q;
        logic [CTR_W-1:0] ivl_q;
        logic             sel_me;
        logic             other_trig;
        logic             qual;
        logic [CTR_W-1:0] cnt_w;
        logic [CTR_W-1:0] shd_w;

        assign sel_me     = cfg_we_i && (wr_ctr == CIDX_W'(i));
        assign other_trig = |(trig_vec & ~(NUM_CTR'(1) << i));
        assign ctrl_wr_vec[i] = sel_me && (wr_reg == REG_CTRL)
                                && !((new_cfg.mode == MODE_TRIG) && other_trig);
        assign ovf_clr_vec[i] = sel_me && (wr_reg == REG_OVF) && cfg_wdata_i[0];

        // Control register, written only when the trigger interlock allows.
        always_ff @(posedge clk) begin
            if (!rst_n)              cfg_q <= '{mode: MODE_OFF, priv: PRIV_ANY, mark: MARK_ANY, sel: 8'd0};
            else if (ctrl_wr_vec[i]) cfg_q <= new_cfg;
        end

        // Sample interval register.
        always_ff @(posedge clk) begin
            if (!rst_n)                          ivl_q <= '0;
            else if (sel_me && wr_reg == REG_IVL) ivl_q <= cfg_wdata_i[CTR_W-1:0];
        end

        assign trig_vec[i] = (cfg_q.mode == MODE_TRIG);
        assign off_vec[i]  = (cfg_q.mode == MODE_OFF);
        assign cnt_vec[i]  = (cfg_q.mode == MODE_COUNT);

        evctr_qual #(.NUM_EVT(NUM_EVT)) u_qual (
            .evt_i      (evt_i),
            .sel_i      (cfg_q.sel),
            .priv_i     (cfg_q.priv),
            .mark_flt_i (cfg_q.mark),
            .sup_i      (priv_sup_i),
            .mark_i     (ctx_mark_i),
            .mark_en_i  (trig_active),
            .qual_o     (qual)
        );

        evctr_cell #(.CTR_W(CTR_W)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (cfg_q.mode),
            .qual_i     (qual),
            .interval_i (ivl_q),
            .ctrl_wr_i  (ctrl_wr_vec[i]),
            .ovf_clr_i  (ovf_clr_vec[i]),
            .snap_i     (snap_i),
            .cnt_o      (cnt_w),
            .shadow_o   (shd_w),
            .ovf_o      (ovf_o[i]),
            .fire_o     (fire_vec[i])
        );

        assign cnt_flat[i*CTR_W +: CTR_W] = cnt_w;
        assign shd_flat[i*CTR_W +: CTR_W] = shd_w;
        assign shd_arr[i]                 = shd_w;
    end

    assign sample_req_o = |fire_vec;

    // Shadow read port; an index past the last counter reads zero.
    always_comb begin
        if ({1'b0, rd_idx_i} < CTR_LIM) rd_data_o = shd_arr[rd_idx_i];
        else                            rd_data_o = '0;
    end

endmodule

// File: rtl/evctr_bank_chk.sv
// Assertion checker for the event counter bank, bound to every instance.
module evctr_bank_chk #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     snap_i,
    input logic                     sample_req_o,
    input logic [NUM_CTR-1:0]       ovf_o,
    input logic [NUM_CTR-1:0]       trig_vec,
    input logic [NUM_CTR-1:0]       off_vec,
    input logic [NUM_CTR-1:0]       cnt_vec,
    input logic [NUM_CTR-1:0]       ctrl_wr_vec,
    input logic [NUM_CTR-1:0]       ovf_clr_vec,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic [NUM_CTR*CTR_W-1:0] shd_flat
);
    // R6: at most one trigger counter at any time
    a_r6_single_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(trig_vec) <= 1);

    // R5: a sample request follows a cycle with a trigger counter present
    a_r5_req_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |-> $past(|trig_vec));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        // R1: an off counter keeps its value unless reconfigured
        a_r1_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
            off_vec[i] && !ctrl_wr_vec[i] |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

        // R10: overflow flag stays set until cleared
        a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_o[i] && !ovf_clr_vec[i] |=> ovf_o[i]);

        // R9: snapshot copies the pre-edge count of a count-mode counter
        a_r9_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
            snap_i && cnt_vec[i] |=> shd_flat[i*CTR_W +: CTR_W] == $past(cnt_flat[i*CTR_W +: CTR_W]));

        // R9: shadow of a counter outside count mode is not disturbed
        a_r9_shadow_keep: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_vec[i] |=> $stable(shd_flat[i*CTR_W +: CTR_W]));
    end

endmodule

bind evctr_bank evctr_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snap_i       (snap_i),
    .sample_req_o (sample_req_o),
    .ovf_o        (ovf_o),
    .trig_vec     (trig_vec),
    .off_vec      (off_vec),
    .cnt_vec      (cnt_vec),
    .ctrl_wr_vec  (ctrl_wr_vec),
    .ovf_clr_vec  (ovf_clr_vec),
    .cnt_flat     (cnt_flat),
    .shd_flat     (shd_flat)
);

// File: tb/evctr_bank_test.sv
// Scoreboard bench for the event counter bank (4 counters, 8-bit, 8 events).
module evctr_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       priv_sup_i = 1'b0;
    logic       ctx_mark_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [3:0] cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic       snap_i = 1'b0;
    logic [1:0] rd_idx_i = '0;
    logic [7:0] rd_data_o;
    logic       sample_req_o;
    logic [3:0] ovf_o;

    int checks = 0;
    int fails = 0;
    int req_seen = 0;
    int req_exp = 0;
    bit done = 0;

    string q_req[$];
    int    q_idx[$];
    int    q_val[$];

    always #5 clk = ~clk;

    evctr_bank #(.NUM_CTR(4), .CTR_W(8), .NUM_EVT(8)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_sup_i(priv_sup_i),
        .ctx_mark_i(ctx_mark_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .snap_i(snap_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .sample_req_o(sample_req_o), .ovf_o(ovf_o)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Monitor: pops expected shadow values and compares them at the read port.
    always @(posedge clk) begin
        #2;
        if (q_idx.size() > 0) begin
            string r;
            int    ix;
            int    v;
            r  = q_req.pop_front();
            ix = q_idx.pop_front();
            v  = q_val.pop_front();
            rd_idx_i = ix[1:0];
            #1;
            check(r, int'(rd_data_o), v);
        end
    end

    // Monitor: counts sample request pulses.
    always @(posedge clk) begin
        #2;
        if (sample_req_o === 1'b1) req_seen++;
    end

    function automatic logic [31:0] ctrl(input int mode, input int sel, input int priv, input int mark);
        return 32'(mode) | (32'(sel) << 8) | (32'(priv) << 16) | (32'(mark) << 18);
    endfunction

    // All driver tasks start and end at a falling edge.
    task automatic wr(input int c, input int r, input logic [31:0] d);
        cfg_we_i = 1'b1;
        cfg_addr_i = {2'(c), 2'(r)};
        cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic ev(input logic [7:0] m, input logic sup, input logic mk, input int n);
        priv_sup_i = sup;
        ctx_mark_i = mk;
        for (int k = 0; k < n; k++) begin
            evt_i = m;
            @(negedge clk);
        end
        evt_i = '0;
    endtask

    task automatic push(input string r, input int ix, input int v);
        q_req.push_back(r);
        q_idx.push_back(ix);
        q_val.push_back(v);
    endtask

    task automatic snap();
        snap_i = 1'b1;
        @(negedge clk);
        snap_i = 1'b0;
    endtask

    task automatic drain();
        while (q_idx.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 ovf", int'(ovf_o), 0);
        check("R11 req", int'(sample_req_o), 0);
        for (int i = 0; i < 4; i++) push("R11 shadow", i, 0);
        drain();

        // R2 and R12: counter 0 counts event 2 only; R1: counter 1 stays off
        wr(0, 0, ctrl(1, 2, 0, 0));
        ev(8'h04, 0, 0, 5);
        ev(8'h08, 0, 0, 2);
        ev(8'h01, 0, 0, 3);
        snap();
        push("R2 select", 0, 5);
        push("R1 off", 1, 0);
        drain();

        // R3: privilege filters on counters 2 and 3
        wr(2, 0, ctrl(1, 4, 1, 0));
        wr(3, 0, ctrl(1, 4, 2, 0));
        ev(8'h10, 0, 0, 3);
        ev(8'h10, 1, 0, 2);
        snap();
        push("R3 user", 2, 3);
        push("R3 sup", 3, 2);
        push("R9 keep", 0, 5);
        drain();

        // R4 and R8: mark filter ignored with no trigger; rewrite clears
        wr(2, 0, ctrl(1, 5, 0, 1));
        ev(8'h20, 0, 0, 4);
        snap();
        push("R4 ignored", 2, 4);
        drain();

        // R5 and R4: counter 3 trigger, interval 3, marked only
        wr(3, 0, ctrl(2, 6, 0, 1));
        wr(3, 1, 32'd3);
        wr(2, 0, ctrl(1, 5, 0, 1));
        ev(8'h20, 0, 0, 3);
        ev(8'h20, 0, 1, 2);
        ev(8'h40, 0, 0, 3);
        ev(8'h40, 0, 1, 2);
        check("R5 no early req", req_seen, req_exp);
        ev(8'h40, 0, 1, 1);
        req_exp++;
        check("R5 req at interval", req_seen, req_exp);
        ev(8'h40, 0, 1, 4);
        req_exp++;
        check("R5 reload", req_seen, req_exp);
        snap();
        push("R4 marked", 2, 2);
        push("R9 trigger not captured", 3, 2);
        drain();

        // R7: interval on a count-mode counter has no effect, no clear
        wr(2, 1, 32'd1);
        ev(8'h20, 0, 1, 3);
        check("R7 no req", req_seen, req_exp);

        // R6: second trigger refused; counter 0 keeps counting
        wr(0, 0, ctrl(2, 2, 0, 0));
        ev(8'h04, 0, 0, 2);
        check("R6 refused no req", req_seen, req_exp);
        snap();
        push("R6 refused", 0, 7);
        push("R7 count kept", 2, 5);
        drain();

        // R6 and R5: after release, counter 0 becomes trigger, interval 2
        wr(3, 0, ctrl(0, 0, 0, 0));
        wr(0, 0, ctrl(2, 2, 0, 0));
        wr(0, 1, 32'd2);
        ev(8'h04, 0, 0, 4);
        req_exp += 2;
        check("R6 accepted", req_seen, req_exp);

        // R10: wrap and sticky overflow on counter 1
        wr(1, 0, ctrl(1, 0, 0, 0));
        ev(8'h01, 0, 0, 255);
        check("R10 no ovf yet", int'(ovf_o[1]), 0);
        ev(8'h01, 0, 0, 1);
        check("R10 ovf set", int'(ovf_o[1]), 1);
        ev(8'h01, 0, 0, 3);
        wr(1, 2, 32'd0);
        check("R10 sticky", int'(ovf_o[1]), 1);
        wr(1, 3, 32'd1);
        check("R12 reg3 ignored", int'(ovf_o[1]), 1);
        snap();
        push("R10 wrapped", 1, 3);
        drain();
        wr(1, 2, 32'd1);
        check("R10 cleared", int'(ovf_o[1]), 0);
        check("R10 others", int'(ovf_o), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule